// File: doc/BRIEF.md
# Parity-Protected Dual-Port Block RAM

This block is a simple dual-port memory of 256 words by 9 bits. One port only writes and the other only reads, and each has its own 8-bit address. Each port acts only while its active-low strobe and its active-low block select are both low. Parameters set, at elaboration, how each port is timed:

- The write port can be clocked, or it can write on the strobe pulse.
- The read port can be combinational, registered, or registered with write-to-read forwarding.

With parity generation on, the memory computes bit 8 of every stored word from data bits 7:0 and ignores input bit 8. With generation off, all nine input bits are stored unchanged. The `par_odd` input selects the parity sense for both generation and checking.

Two error flags are provided. The write-side flag checks the incoming 9-bit word during a write, so parity supplied from upstream can be checked. The read-side flag checks the word shown on the read data output.

Top module: `pdp_bram`

## Requirements
- R1: In clocked-write mode, a write is captured on the rising write clock edge. A registered read then returns that word on `dout` one read clock edge after the read is issued.
- R2: A write happens only when `wr_n` and `wr_blk_n` are both low. If either is high, the addressed word is left unchanged.
- R3: A read happens only when `rd_n` and `rd_blk_n` are both low. If either is high, `dout` and `rd_perr` keep their previous values, even when `raddr` or `par_odd` changes.
- R4: With parity generation on, input bit 8 is ignored. Stored bit 8 is chosen so that the 9-bit word has an odd number of ones when `par_odd` is 1, and an even number when `par_odd` is 0.
- R5: During an active write, `wr_perr` is 1 exactly when the 9-bit input word `din` fails the parity selected by `par_odd`.
- R6: `rd_perr` is 1 exactly when the word on `dout` fails the parity selected by `par_odd` at the time of the read. It appears in the same cycle as the read data.
- R7: In registered read mode, if a read and a write to the same address share a clock edge, the read returns the word stored before that write.
- R8: In forwarding read mode, if a read and a write to the same address share a clock edge, the read returns the word being written.
- R9: With parity generation off, all nine bits of `din` are stored and read back unchanged.
- R10: In pulse-write mode, the word is written on the rising edge of `wr_n` while `wr_blk_n` is low. Before that edge, the old word is still read.
- R11: In combinational read mode, `dout` follows the word at `raddr` while the read is enabled. When the read strobe rises, `dout` holds the last word read.
- R12: The reset is synchronous and active low. It clears `dout` and `rd_perr` to 0. This happens on the read clock in the registered modes and on a read strobe rising edge in the combinational mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, used in clocked-write mode |
| rd_clk | input | 1 | Read clock, used in the registered read modes |
| rst_n | input | 1 | Synchronous active-low reset of the read output state |
| wr_n | input | 1 | Active-low write strobe |
| wr_blk_n | input | 1 | Active-low write block select |
| rd_n | input | 1 | Active-low read strobe |
| rd_blk_n | input | 1 | Active-low read block select |
| waddr | input | 8 | Write address |
| raddr | input | 8 | Read address |
| din | input | 9 | Write data; bit 8 is the parity bit supplied from upstream |
| par_odd | input | 1 | Parity sense: 1 selects odd, 0 selects even |
| dout | output | 9 | Read data; bit 8 is the parity bit |
| wr_perr | output | 1 | Parity error on the incoming write word |
| rd_perr | output | 1 | Parity error on the read data word |

## Verification
A table of words is written and read back in the default configuration. The table mixes data values of both parity classes with both `par_odd` settings, and sets input bit 8 against the generated value. This separates a correct parity generator from one that copies input bit 8 or inverts the sense.

Same-address write-and-read cycles are run in both the registered and the forwarding instance, which tells old-data return from new-data return. Strobes and block selects are driven high one at a time, and each must separately block the access.

In the pulse-write, combinational-read instance, the word is read in the middle of a write pulse and again after it. This shows that the write lands on the rising edge of the strobe and that the read output holds its value when the strobe rises.

// File: rtl/pdpram_pkg.sv
// Shared types for the parity-protected dual-port RAM.
// Assumes: the mode enums are used only as elaboration-time parameters.
package pdpram_pkg;

    typedef enum logic {
        WR_PULSE   = 1'b0,  // write lands on the rising edge of the strobe
        WR_CLOCKED = 1'b1   // write captured on the write clock edge
    } wr_mode_e;

    typedef enum logic [1:0] {
        RD_COMB = 2'd0,     // combinational read, held on strobe release
        RD_REG  = 2'd1,     // registered read, old data on a collision
        RD_FWD  = 2'd2      // registered read, write data forwarded
    } rd_mode_e;

endpackage

// File: rtl/pdpram_parity.sv
// Parity helper: gives the parity bit for a data field and flags a word
// whose parity (data plus the extra bit) is not the sense chosen by odd.
// Assumes: purely combinational; odd = 1 selects odd parity.
module pdpram_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              extra,
    input  logic              odd,
    output logic              gen_bit,
    output logic              err
);

    // Bit that brings the total count of ones to the selected sense.
    always_comb gen_bit = (^data) ^ odd;

    // Mismatch between the word's actual parity and the selected sense.
    always_comb err = ((^data) ^ extra) != odd;

endmodule

// File: rtl/pdpram_wport.sv
// Write port: decodes the strobe and select, forms the word to store
// (with or without generated parity), checks the incoming parity, and
// picks the edge that commits the write.
// Assumes: in pulse mode, the address, data and select are held until the
// strobe has risen.
module pdpram_wport #(
    parameter int                  DATA_W  = 8,
    parameter pdpram_pkg::wr_mode_e WR_MODE = pdpram_pkg::WR_CLOCKED,
    parameter bit                  PAR_GEN = 1'b1,
    localparam int                 WORD_W  = DATA_W + 1
) (
    input  logic              wr_clk,
    input  logic              wr_n,
    input  logic              wr_blk_n,
    input  logic [WORD_W-1:0] din,
    input  logic              par_odd,
    output logic              wclk,
    output logic              we,
    output logic              wr_act,
    output logic [WORD_W-1:0] wword,
    output logic              wr_perr
);

    logic gen_bit;
    logic in_err;

    pdpram_parity #(.DATA_W(DATA_W)) u_par (
        .data    (din[DATA_W-1:0]),
        .extra   (din[DATA_W]),
        .odd     (par_odd),
        .gen_bit (gen_bit),
        .err     (in_err)
    );

    // The port is active only while both active-low controls are low.
    always_comb wr_act = ~wr_n & ~wr_blk_n;

    // Flag an incoming word with bad parity while a write is in progress.
    always_comb wr_perr = wr_act & in_err;

    generate
        if (PAR_GEN) begin : g_gen
            // Replace input bit 8 with the generated parity bit.
            always_comb wword = {gen_bit, din[DATA_W-1:0]};
        end else begin : g_raw
            // Store the input word unchanged.
            always_comb wword = din;
        end

        if (WR_MODE == pdpram_pkg::WR_CLOCKED) begin : g_clk
            // Commit on the write clock while the port is active.
            assign wclk = wr_clk;
            always_comb we = wr_act;
        end else begin : g_pulse
            // Commit on the trailing (rising) strobe edge; select still low.
            assign wclk = wr_n;
            always_comb we = ~wr_blk_n;
        end
    endgenerate

endmodule

// File: rtl/pdpram_store.sv
// Storage array: one write port on the selected commit edge and one
// combinational read port.
// Assumes: the contents are not reset; software writes before it reads.
module pdpram_store #(
    parameter int  ADDR_W = 8,
    parameter int  WORD_W = 9,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wword,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rword
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Write the word into the array on the commit edge.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wword;
        end
    end

    // Combinational read of the addressed word.
    always_comb rword = mem[raddr];

    // R2
    store_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wword));

endmodule

// File: rtl/pdpram_rport.sv
// Read port: combinational with a hold register, registered, or registered
// with same-edge forwarding from the write port. The read parity flag is
// computed on the exact word that reaches the output.
// Assumes: for forwarding, the read and write clocks are the same clock.
module pdpram_rport #(
    parameter int                  ADDR_W  = 8,
    parameter int                  DATA_W  = 8,
    parameter pdpram_pkg::rd_mode_e RD_MODE = pdpram_pkg::RD_REG,
    localparam int                 WORD_W  = DATA_W + 1
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              rd_blk_n,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [WORD_W-1:0] rword,
    input  logic              par_odd,
    input  logic              wr_act,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] dout,
    output logic              rd_perr
);

    logic              rd_act;
    logic [WORD_W-1:0] chk_word;
    logic              chk_err;
    logic              unused_gen;

    // Read is enabled only while both active-low controls are low.
    always_comb rd_act = ~rd_n & ~rd_blk_n;

    pdpram_parity #(.DATA_W(DATA_W)) u_par (
        .data    (chk_word[DATA_W-1:0]),
        .extra   (chk_word[DATA_W]),
        .odd     (par_odd),
        .gen_bit (unused_gen),
        .err     (chk_err)
    );

    generate
        if (RD_MODE == pdpram_pkg::RD_COMB) begin : g_comb
            logic [WORD_W-1:0] hold_q;
            logic              hold_perr_q;

            // The word being checked is the array output itself.
            always_comb chk_word = rword;

            // Capture the last word read when the strobe is released.
            always_ff @(posedge rd_n) begin
                if (!rst_n) begin
                    hold_q      <= '0;
                    hold_perr_q <= 1'b0;
                end else if (!rd_blk_n) begin
                    hold_q      <= rword;
                    hold_perr_q <= chk_err;
                end
            end

            // Follow the array while enabled; otherwise show the held word.
            always_comb begin
                dout    = rd_act ? rword   : hold_q;
                rd_perr = rd_act ? chk_err : hold_perr_q;
            end
        end else begin : g_sync
            logic [WORD_W-1:0] dout_q;
            logic              perr_q;
            logic              collide;

            // Same-edge write to the address being read.
            always_comb collide = wr_act && (waddr == raddr);

            // Choose the source word: forwarded write data or array data.
            always_comb begin
                if ((RD_MODE == pdpram_pkg::RD_FWD) && collide) begin
                    chk_word = wword;
                end else begin
                    chk_word = rword;
                end
            end

            // Register the word and its parity flag on the read clock.
            always_ff @(posedge rd_clk) begin
                if (!rst_n) begin
                    dout_q <= '0;
                    perr_q <= 1'b0;
                end else if (rd_act) begin
                    dout_q <= chk_word;
                    perr_q <= chk_err;
                end
            end

            always_comb begin
                dout    = dout_q;
                rd_perr = perr_q;
            end

            // R3
            read_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
                !rd_act |=> $stable(dout) && $stable(rd_perr));

            // R6
            read_perr_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
                rd_act |=> rd_perr == ((^dout) != $past(par_odd)));

            if (RD_MODE == pdpram_pkg::RD_FWD) begin : g_fwd_chk
                // R8
                read_fwd_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
                    (rd_act && collide) |=> dout == $past(wword));
            end else begin : g_old_chk
                // R7
                read_old_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
                    (rd_act && collide) |=> dout == $past(rword));
            end
        end
    endgenerate

endmodule

// File: rtl/pdp_bram.sv
// Parity-protected simple dual-port RAM top: write port, storage array and
// read port, with timing and parity generation fixed by parameters.
// Assumes: the synchronous reset only clears the read output state.
module pdp_bram #(
    parameter int                  ADDR_W  = 8,
    parameter int                  DATA_W  = 8,
    parameter pdpram_pkg::wr_mode_e WR_MODE = pdpram_pkg::WR_CLOCKED,
    parameter pdpram_pkg::rd_mode_e RD_MODE = pdpram_pkg::RD_REG,
    parameter bit                  PAR_GEN = 1'b1,
    localparam int                 WORD_W  = DATA_W + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              wr_blk_n,
    input  logic              rd_n,
    input  logic              rd_blk_n,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [WORD_W-1:0] din,
    input  logic              par_odd,
    output logic [WORD_W-1:0] dout,
    output logic              wr_perr,
    output logic              rd_perr
);

    logic              wclk;
    logic              we;
    logic              wr_act;
    logic [WORD_W-1:0] wword;
    logic [WORD_W-1:0] rword;

    pdpram_wport #(
        .DATA_W  (DATA_W),
        .WR_MODE (WR_MODE),
        .PAR_GEN (PAR_GEN)
    ) u_wport (
        .wr_clk   (wr_clk),
        .wr_n     (wr_n),
        .wr_blk_n (wr_blk_n),
        .din      (din),
        .par_odd  (par_odd),
        .wclk     (wclk),
        .we       (we),
        .wr_act   (wr_act),
        .wword    (wword),
        .wr_perr  (wr_perr)
    );

    pdpram_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_store (
        .wclk  (wclk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wword (wword),
        .raddr (raddr),
        .rword (rword)
    );

    pdpram_rport #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RD_MODE (RD_MODE)
    ) u_rport (
        .rd_clk   (rd_clk),
        .rst_n    (rst_n),
        .rd_n     (rd_n),
        .rd_blk_n (rd_blk_n),
        .raddr    (raddr),
        .rword    (rword),
        .par_odd  (par_odd),
        .wr_act   (wr_act),
        .waddr    (waddr),
        .wword    (wword),
        .dout     (dout),
        .rd_perr  (rd_perr)
    );

endmodule

// File: tb/pdp_bram_bench.sv
`timescale 1ns/1ps
module pdp_bram_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] waddr = '0;
    logic [7:0] raddr = '0;
    logic [8:0] din = '0;
    logic       par_odd = 1'b0;

    // Default instance: clocked write, registered read, parity generated.
    logic a_wr_n = 1'b1, a_wb_n = 1'b1, a_rd_n = 1'b1, a_rb_n = 1'b1;
    logic [8:0] a_dout;
    logic a_wperr, a_rperr;
    // Forwarding instance: clocked write, forwarding read, raw storage.
    logic t_wr_n = 1'b1, t_wb_n = 1'b1, t_rd_n = 1'b1, t_rb_n = 1'b1;
    logic [8:0] t_dout;
    logic t_wperr, t_rperr;
    // Pulse instance: pulse write, combinational read, raw storage.
    logic s_wr_n = 1'b1, s_wb_n = 1'b1, s_rd_n = 1'b1, s_rb_n = 1'b1;
    logic [8:0] s_dout;
    logic s_wperr, s_rperr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pdp_bram u_pdp_bram (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_n(a_wr_n), .wr_blk_n(a_wb_n), .rd_n(a_rd_n), .rd_blk_n(a_rb_n),
        .waddr(waddr), .raddr(raddr), .din(din), .par_odd(par_odd),
        .dout(a_dout), .wr_perr(a_wperr), .rd_perr(a_rperr));

    pdp_bram #(.RD_MODE(pdpram_pkg::RD_FWD), .PAR_GEN(1'b0)) u_trans (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_n(t_wr_n), .wr_blk_n(t_wb_n), .rd_n(t_rd_n), .rd_blk_n(t_rb_n),
        .waddr(waddr), .raddr(raddr), .din(din), .par_odd(par_odd),
        .dout(t_dout), .wr_perr(t_wperr), .rd_perr(t_rperr));

    pdp_bram #(.WR_MODE(pdpram_pkg::WR_PULSE), .RD_MODE(pdpram_pkg::RD_COMB),
               .PAR_GEN(1'b0)) u_async (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_n(s_wr_n), .wr_blk_n(s_wb_n), .rd_n(s_rd_n), .rd_blk_n(s_rb_n),
        .waddr(waddr), .raddr(raddr), .din(din), .par_odd(par_odd),
        .dout(s_dout), .wr_perr(s_wperr), .rd_perr(s_rperr));

    // Word expected in storage when parity is generated (R4).
    function automatic logic [8:0] gen_word(input logic [7:0] d, input logic po);
        return {(^d) ^ po, d};
    endfunction

    // 1 when a 9-bit word fails the selected parity sense.
    function automatic logic bad_par(input logic [8:0] w, input logic po);
        return (^w) != po;
    endfunction

    task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    // One clocked write on the default instance; checks wr_perr mid-cycle.
    task automatic a_write(input logic [7:0] ad, input logic [8:0] d, input logic po,
                           input logic sel_n, input logic stb_n);
        @(negedge clk);
        waddr = ad; din = d; par_odd = po; a_wr_n = stb_n; a_wb_n = sel_n;
        #1;
        if (!sel_n && !stb_n) chk("R5", {8'h0, a_wperr}, {8'h0, bad_par(d, po)});
        @(negedge clk);
        a_wr_n = 1'b1; a_wb_n = 1'b1;
    endtask

    // One registered read on the default instance; result valid afterwards.
    task automatic a_read(input logic [7:0] ad, input logic po);
        @(negedge clk);
        raddr = ad; par_odd = po; a_rd_n = 1'b0; a_rb_n = 1'b0;
        @(negedge clk);
        a_rd_n = 1'b1; a_rb_n = 1'b1;
    endtask

    // Vectors: {address, input word, parity sense}; bit 8 is set against
    // the generated value in several entries.
    localparam logic [17:0] VEC [8] = '{
        {8'h00, 9'h1A5, 1'b1}, {8'h01, 9'h0A5, 1'b0},
        {8'h02, 9'h000, 1'b1}, {8'h03, 9'h1FF, 1'b0},
        {8'h7F, 9'h101, 1'b1}, {8'h80, 9'h03C, 1'b0},
        {8'hFE, 9'h17E, 1'b1}, {8'hFF, 9'h0FF, 1'b1}
    };

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset; the pulse instance clears its hold register on a strobe rise.
        repeat (3) @(negedge clk);
        s_rb_n = 1'b0; s_rd_n = 1'b0; #2 s_rd_n = 1'b1; s_rb_n = 1'b1;
        @(negedge clk);
        chk("R12", a_dout, 9'h000);
        chk("R12", {8'h0, a_rperr}, 9'h000);
        chk("R12", t_dout, 9'h000);
        chk("R12", s_dout, 9'h000);
        rst_n = 1'b1;

        // Table walk: R1 data path, R4 generated parity, R5 and R6 flags.
        for (int i = 0; i < 8; i++) begin
            a_write(VEC[i][17:10], VEC[i][9:1], VEC[i][0], 1'b0, 1'b0);
            a_read(VEC[i][17:10], VEC[i][0]);
            chk("R1", a_dout, gen_word(VEC[i][8:1], VEC[i][0]));
            chk("R4", {8'h0, a_dout[8]}, {8'h0, (^VEC[i][8:1]) ^ VEC[i][0]});
            chk("R6", {8'h0, a_rperr}, 9'h000);
        end

        // R6: stored with odd sense, read back with even sense.
        a_write(8'h40, 9'h007, 1'b1, 1'b0, 1'b0);
        a_read(8'h40, 1'b0);
        chk("R6", a_dout, 9'h007);
        chk("R6", {8'h0, a_rperr}, 9'h001);

        // R7: same-edge write and read to one address returns the old word.
        a_write(8'h41, 9'h011, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        waddr = 8'h41; raddr = 8'h41; din = 9'h013; par_odd = 1'b0;
        a_wr_n = 1'b0; a_wb_n = 1'b0; a_rd_n = 1'b0; a_rb_n = 1'b0;
        @(negedge clk);
        a_wr_n = 1'b1; a_wb_n = 1'b1; a_rd_n = 1'b1; a_rb_n = 1'b1;
        chk("R7", a_dout, 9'h011);
        a_read(8'h41, 1'b0);
        chk("R7", a_dout, 9'h113);

        // R3: either control high blocks the read; parity change ignored.
        @(negedge clk);
        raddr = 8'h40; par_odd = 1'b1; a_rd_n = 1'b0; a_rb_n = 1'b1;
        @(negedge clk);
        a_rd_n = 1'b1; a_rb_n = 1'b0;
        @(negedge clk);
        a_rb_n = 1'b1;
        chk("R3", a_dout, 9'h113);
        chk("R3", {8'h0, a_rperr}, 9'h000);

        // R2: write blocked by select high, then by strobe high.
        a_write(8'h41, 9'h000, 1'b0, 1'b1, 1'b0);
        a_write(8'h41, 9'h000, 1'b0, 1'b0, 1'b1);
        a_read(8'h41, 1'b0);
        chk("R2", a_dout, 9'h113);

        // R9 and R8 on the forwarding instance (raw storage).
        @(negedge clk);
        waddr = 8'h30; din = 9'h1FF; par_odd = 1'b1; t_wr_n = 1'b0; t_wb_n = 1'b0;
        @(negedge clk);
        t_wr_n = 1'b1; t_wb_n = 1'b1;
        raddr = 8'h30; t_rd_n = 1'b0; t_rb_n = 1'b0;
        @(negedge clk);
        t_rd_n = 1'b1; t_rb_n = 1'b1;
        chk("R9", t_dout, 9'h1FF);
        chk("R6", {8'h0, t_rperr}, 9'h000);
        din = 9'h0AA; t_wr_n = 1'b0; t_wb_n = 1'b0; t_rd_n = 1'b0; t_rb_n = 1'b0;
        @(negedge clk);
        t_wr_n = 1'b1; t_wb_n = 1'b1; t_rd_n = 1'b1; t_rb_n = 1'b1;
        chk("R8", t_dout, 9'h0AA);
        chk("R6", {8'h0, t_rperr}, 9'h001);

        // R10 and R11 on the pulse instance.
        waddr = 8'h20; din = 9'h055; par_odd = 1'b1;
        s_wb_n = 1'b0; s_wr_n = 1'b0; #2 s_wr_n = 1'b1; #1 s_wb_n = 1'b1;
        #2;
        din = 9'h1C3; s_wb_n = 1'b0; s_wr_n = 1'b0;
        raddr = 8'h20; s_rb_n = 1'b0; s_rd_n = 1'b0;
        #1;
        chk("R10", s_dout, 9'h055);
        chk("R5", {8'h0, s_wperr}, 9'h000);
        s_wr_n = 1'b1;
        #1;
        s_wb_n = 1'b1;
        chk("R10", s_dout, 9'h1C3);
        chk("R11", s_dout, 9'h1C3);
        s_rd_n = 1'b1;
        #1;
        s_rb_n = 1'b1; raddr = 8'h21;
        #1;
        chk("R11", s_dout, 9'h1C3);
        chk("R11", {8'h0, s_rperr}, 9'h000);

        // R5, R6 and R9 with a bad-parity raw word on the pulse instance.
        waddr = 8'h22; din = 9'h001; par_odd = 1'b0;
        s_wb_n = 1'b0; s_wr_n = 1'b0;
        #1;
        chk("R5", {8'h0, s_wperr}, 9'h001);
        s_wr_n = 1'b1; #1 s_wb_n = 1'b1;
        raddr = 8'h22; s_rb_n = 1'b0; s_rd_n = 1'b0;
        #1;
        chk("R9", s_dout, 9'h001);
        chk("R6", {8'h0, s_rperr}, 9'h001);
        s_rd_n = 1'b1; #1 s_rb_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule